// File: doc/BRIEF.md
# Triplex LCD Multiplex Driver

This block drives a three-backplane, twelve-segment liquid crystal panel at 1/3 duty and 1/3 bias. A host writes the 36 segment states through a three-wire serial port made of a select line, a data line and a serial clock. The block keeps the received image in its own latches and repeats the display frame on its own, so the host never has to refresh it.

Every output line carries a 2-bit level code, and an analog stage outside the block turns that code into a voltage. A free-running oscillator clock paces a frame of six equal slots. In each slot one backplane is active and has one polarity, and every line is driven so that its average voltage over a whole frame is zero. New serial data goes into a shift register that sits apart from the displayed image. The image changes only when a complete, correctly sized transfer ends, so the panel never shows a partly loaded pattern.

Top module: `lcd_triplex_drv`

## Requirements
- R1: A synchronous active-high reset sets all 36 displayed bits to OFF and restarts the frame in the first slot (backplane A, positive) at cycle zero of that slot.
- R2: A frame is six slots of 32 oscillator clocks each (192 clocks in all), in the order A+, A-, B+, B-, C+, C-, and then it repeats.
- R3: Level codes are 3 = full supply, 2 = two-thirds, 1 = one-third and 0 = ground. In a positive slot the active backplane is at 3 and the other two are at 1. In a negative slot the active backplane is at 0 and the other two are at 2.
- R4: In a positive slot a segment whose bit is ON for the active backplane is at 0, and an OFF segment is at 2. In a negative slot ON is at 3 and OFF is at 1.
- R5: Displayed bit index = backplane*12 + segment, with backplane A=0, B=1, C=2 and segment 0..11. Serial bits enter MSB first, so the first bit of a 36-bit transfer lands in bit 35 (backplane C, last segment) and the last bit lands in bit 0.
- R6: Serial clock rising edges that arrive while select is low shift nothing and count nothing.
- R7: The displayed bits take the shift register contents only when select falls and exactly 36 rising serial clock edges were received during that select period. A transfer of 0, 35 or 37 edges leaves the display unchanged.
- R8: While a transfer is in progress the outputs keep showing the previously latched image.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Serial select, active high, asynchronous |
| sck_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data, MSB first |
| bp_lvl_o | output | 6 | Backplane level codes, bits [2b+1:2b] for backplane b (A=0) |
| seg_lvl_o | output | 24 | Segment level codes, bits [2s+1:2s] for segment s |

## Verification
Two functions can fall in the same oscillator cycle: the latch update started by select falling, and the step from one frame slot to the next. The bench drops select at several offsets just before and at a slot boundary. After each drop it checks every slot of the following frame, to see that the slot sequence kept its order and that each slot shows the whole new image and never a mix of old and new. A second coincidence is a serial clock edge that arrives in the same cycle in which select is seen low. That edge must be ignored, and the bench judges it through the 37-edge and idle-clock cases, which must leave the display unchanged.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_GND   = 2'd0;
    localparam lvl_t LVL_THIRD = 2'd1;
    localparam lvl_t LVL_TWO3  = 2'd2;
    localparam lvl_t LVL_FULL  = 2'd3;
endpackage

// File: rtl/lcd_serial_rx.sv
module lcd_serial_rx #(
    parameter int NBITS = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             sck_i,
    input  logic             sdi_i,
    output logic [NBITS-1:0] seg_bits_o
);
    localparam int CW = $clog2(NBITS + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(NBITS);
    localparam logic [CW-1:0] CNT_SAT  = CW'(NBITS + 1);

    typedef struct packed {
        logic [2:0]       sel_sy;
        logic [2:0]       sck_sy;
        logic [1:0]       sdi_sy;
        logic [NBITS-1:0] shreg;
        logic [CW-1:0]    cnt;
        logic [NBITS-1:0] latch;
    } rx_t;

    rx_t rx_d, rx_q;
    logic sel_now, sel_fall, sck_rise;

    always_comb begin
        rx_d        = rx_q;
        rx_d.sel_sy = {rx_q.sel_sy[1:0], sel_i};
        rx_d.sck_sy = {rx_q.sck_sy[1:0], sck_i};
        rx_d.sdi_sy = {rx_q.sdi_sy[0], sdi_i};
        sel_now     = rx_q.sel_sy[1];
        sel_fall    = rx_q.sel_sy[2] & ~rx_q.sel_sy[1];
        sck_rise    = rx_q.sck_sy[1] & ~rx_q.sck_sy[2];
        if (sel_now && sck_rise) begin
            rx_d.shreg = {rx_q.shreg[NBITS-2:0], rx_q.sdi_sy[1]};
            if (rx_q.cnt != CNT_SAT) rx_d.cnt = rx_q.cnt + 1'b1;
        end
        if (!sel_now) rx_d.cnt = '0;
        if (sel_fall && (rx_q.cnt == CNT_FULL)) rx_d.latch = rx_q.shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) rx_q <= '0;
        else     rx_q <= rx_d;
    end

    assign seg_bits_o = rx_q.latch;

    // R7: the image moves only in the cycle after a detected select fall
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !sel_fall |=> $stable(rx_q.latch));
    // R6: no edge counting while select is low
    a_r6_idle_count: assert property (@(posedge clk) disable iff (rst)
        !sel_now |=> (rx_q.cnt == '0));
    // R1: reset blanks the image
    a_r1_reset_blank: assert property (@(posedge clk)
        rst |=> (rx_q.latch == '0));
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer #(
    parameter int SLOT_CYC = 32,
    parameter int NSLOT    = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic [$clog2(NSLOT)-2:0]   bp_idx_o,
    output logic                       neg_o
);
    localparam int CTW = $clog2(SLOT_CYC);
    localparam int SW  = $clog2(NSLOT);
    localparam logic [CTW-1:0] CNT_MAX  = CTW'(SLOT_CYC - 1);
    localparam logic [SW-1:0]  SLOT_MAX = SW'(NSLOT - 1);

    typedef struct packed {
        logic [CTW-1:0] cnt;
        logic [SW-1:0]  slot;
    } ft_t;

    ft_t ft_d, ft_q;

    always_comb begin
        ft_d = ft_q;
        if (ft_q.cnt == CNT_MAX) begin
            ft_d.cnt  = '0;
            ft_d.slot = (ft_q.slot == SLOT_MAX) ? '0 : ft_q.slot + 1'b1;
        end else begin
            ft_d.cnt = ft_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ft_q <= '0;
        else     ft_q <= ft_d;
    end

    assign bp_idx_o = ft_q.slot[SW-1:1];
    assign neg_o    = ft_q.slot[0];

    // R2: counters stay inside their ranges
    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        (ft_q.cnt <= CNT_MAX) && (ft_q.slot <= SLOT_MAX));
    // R2: the slot steps by one, with wrap, after the last cycle of a slot
    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (ft_q.cnt == CNT_MAX) |=> (ft_q.cnt == '0) &&
        (ft_q.slot == (($past(ft_q.slot) == SLOT_MAX) ? SW'(0) : SW'($past(ft_q.slot) + 1'b1))));
    // R2: the slot holds within a slot period
    a_r2_slot_hold: assert property (@(posedge clk) disable iff (rst)
        (ft_q.cnt != CNT_MAX) |=> $stable(ft_q.slot));
endmodule

// File: rtl/lcd_level_mux.sv
module lcd_level_mux
    import lcd_pkg::*;
#(
    parameter int NBP  = 3,
    parameter int NSEG = 12,
    parameter int BW   = 2
) (
    input  logic [NBP*NSEG-1:0] seg_bits_i,
    input  logic [BW-1:0]       bp_idx_i,
    input  logic                neg_i,
    output logic [NBP*2-1:0]    bp_lvl_o,
    output logic [NSEG*2-1:0]   seg_lvl_o
);
    for (genvar b = 0; b < NBP; b++) begin : g_bp
        always_comb begin
            if (bp_idx_i == BW'(b)) bp_lvl_o[2*b +: 2] = neg_i ? LVL_GND  : LVL_FULL;
            else                    bp_lvl_o[2*b +: 2] = neg_i ? LVL_TWO3 : LVL_THIRD;
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        logic seg_on;
        always_comb begin
            seg_on = 1'b0;
            for (int b = 0; b < NBP; b++)
                if (bp_idx_i == BW'(b)) seg_on = seg_bits_i[b*NSEG + s];
            if (seg_on) seg_lvl_o[2*s +: 2] = neg_i ? LVL_FULL  : LVL_GND;
            else        seg_lvl_o[2*s +: 2] = neg_i ? LVL_THIRD : LVL_TWO3;
        end
    end
endmodule

// File: rtl/lcd_triplex_drv.sv
module lcd_triplex_drv #(
    parameter int NBP      = 3,
    parameter int NSEG     = 12,
    parameter int SLOT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              sck_i,
    input  logic              sdi_i,
    output logic [NBP*2-1:0]  bp_lvl_o,
    output logic [NSEG*2-1:0] seg_lvl_o
);
    localparam int NBITS = NBP * NSEG;
    localparam int NSLOT = 2 * NBP;
    localparam int BW    = $clog2(NSLOT) - 1;

    logic [NBITS-1:0] seg_bits;
    logic [BW-1:0]    bp_idx;
    logic             neg;

    lcd_serial_rx #(.NBITS(NBITS)) u_rx (
        .clk(clk), .rst(rst), .sel_i(sel_i), .sck_i(sck_i), .sdi_i(sdi_i),
        .seg_bits_o(seg_bits)
    );

    lcd_frame_timer #(.SLOT_CYC(SLOT_CYC), .NSLOT(NSLOT)) u_timer (
        .clk(clk), .rst(rst), .bp_idx_o(bp_idx), .neg_o(neg)
    );

    lcd_level_mux #(.NBP(NBP), .NSEG(NSEG), .BW(BW)) u_mux (
        .seg_bits_i(seg_bits), .bp_idx_i(bp_idx), .neg_i(neg),
        .bp_lvl_o(bp_lvl_o), .seg_lvl_o(seg_lvl_o)
    );

    logic [NBP-1:0]  bp_extreme;
    logic [NSEG-1:0] seg_odd;
    for (genvar b = 0; b < NBP; b++) begin : g_chk_bp
        assign bp_extreme[b] = (bp_lvl_o[2*b] == bp_lvl_o[2*b+1]);
    end
    for (genvar s = 0; s < NSEG; s++) begin : g_chk_seg
        assign seg_odd[s] = seg_lvl_o[2*s];
    end

    // R3: exactly one backplane sits at a supply rail
    a_r3_one_active: assert property (@(posedge clk) disable iff (rst)
        $countones(bp_extreme) == 1);
    // R4: in a positive slot every segment code is 0 or 2
    a_r4_pos_even: assert property (@(posedge clk) disable iff (rst)
        !neg |-> (seg_odd == '0));
    // R4: in a negative slot every segment code is 1 or 3
    a_r4_neg_odd: assert property (@(posedge clk) disable iff (rst)
        neg |-> (seg_odd == '1));
endmodule

// File: tb/sim_lcd_triplex_drv.sv
module sim_lcd_triplex_drv;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic [5:0]  bp_lvl;
    logic [23:0] seg_lvl;
    int n = 0;
    int checks = 0, fails = 0;
    bit done = 0;
    logic [35:0] model = '0;

    always #5 clk = ~clk;

    lcd_triplex_drv u0 (
        .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
        .bp_lvl_o(bp_lvl), .seg_lvl_o(seg_lvl)
    );

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    // {edge count, data}
    localparam logic [41:0] VEC [9] = '{
        {6'd36, 36'hFFFFFFFFF},
        {6'd36, 36'h000000000},
        {6'd36, 36'hAAAAAAAAA},
        {6'd35, 36'h123456789},
        {6'd36, 36'h800000001},
        {6'd37, 36'hFFF000FFF},
        {6'd36, 36'h000FFF000},
        {6'd0,  36'hFFFFFFFFF},
        {6'd36, 36'h5A5A5A5A5}
    };

    function automatic logic [29:0] expect_out(input int cyc, input logic [35:0] m);
        logic [29:0] r;
        int slot, bp;
        bit ng;
        slot = (cyc / 32) % 6;
        bp = slot / 2;
        ng = (slot % 2) == 1;
        for (int b = 0; b < 3; b++)
            r[24 + 2*b +: 2] = (b == bp) ? (ng ? 2'd0 : 2'd3) : (ng ? 2'd2 : 2'd1);
        for (int s = 0; s < 12; s++)
            r[2*s +: 2] = m[bp*12 + s] ? (ng ? 2'd3 : 2'd0) : (ng ? 2'd1 : 2'd2);
        return r;
    endfunction

    task automatic check(input string tag);
        logic [29:0] exp_v, act_v;
        exp_v = expect_out(n, model);
        act_v = {bp_lvl, seg_lvl};
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act_v, exp_v);
        end
    endtask

    task automatic check_frame(input string tag);
        for (int k = 0; k < 6; k++) begin
            while ((n % 32) != 16) @(negedge clk);
            check(tag);
            @(negedge clk);
        end
    endtask

    task automatic shift_bits(input logic [35:0] d, input int cnt);
        sel = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < cnt; i++) begin
            sdi = (i < 36) ? d[35 - i] : 1'b0;
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic drop_sel();
        sel = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state");
        rst = 1'b0;

        // R2 slot boundaries and frame wrap
        while (n != 31) @(negedge clk);
        check("R2 last cycle of A+");
        @(negedge clk);
        check("R2 first cycle of A-");
        while ((n % 192) != 191) @(negedge clk);
        check("R2 last cycle of C-");
        @(negedge clk);
        check("R2 frame wrap to A+");
        check_frame("R3 R4 blank frame");

        // table walk: R5 mapping, R7 length gate
        for (int v = 0; v < 9; v++) begin
            shift_bits(VEC[v][35:0], int'(VEC[v][41:36]));
            drop_sel();
            if (VEC[v][41:36] == 6'd36) model = VEC[v][35:0];
            check_frame((VEC[v][41:36] == 6'd36) ? "R5 R3 R4 loaded image" : "R7 wrong length ignored");
        end

        // R6: clocks with select low do nothing
        for (int i = 0; i < 36; i++) begin
            sdi = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b1;
            repeat (3) @(negedge clk);
            sck = 1'b0;
            repeat (3) @(negedge clk);
        end
        check_frame("R6 idle clocks ignored");
        shift_bits(36'h0F0F0F0F0, 36);
        drop_sel();
        model = 36'h0F0F0F0F0;
        check_frame("R6 count clean after idle clocks");

        // R8: image held while shifting
        shift_bits(36'hFFFFFFFFF, 20);
        check_frame("R8 old image during transfer");
        shift_bits(36'hFFFFFFFFF, 0);
        sel = 1'b1;
        drop_sel();
        check_frame("R8 R7 partial transfer dropped");

        // latch update coinciding with slot boundary
        for (int k = 0; k < 5; k++) begin
            logic [35:0] pat;
            pat = 36'h111111111 << k;
            shift_bits(pat, 36);
            while ((n % 32) != (29 + k) % 32) @(negedge clk);
            sel = 1'b0;
            repeat (8) @(negedge clk);
            model = pat;
            check_frame("R7 R2 load at slot boundary");
        end

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model = '0;
        check("R1 reset clears image and frame");
        rst = 1'b0;
        check_frame("R1 blank after reset");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule